// File: doc/BRIEF.md
# Paged Register Access Unit

This block sits between a byte-wide CPU register port and the register file of a bus-interface controller. The CPU sees eight byte registers placed on a four-byte stride, so the register slot comes from address bits [4:2] and the two lowest address bits are ignored. Most accesses go unchanged to the controller core through a forwarding port. A small second bank of registers lives inside this block and is reached through a one-shot page mechanism.

Software selects a page by writing a page command to the auxiliary command slot (slot 5). A page command has the upper nibble 0x5, and the lower nibble carries the page number. The page stays pending only until the next access to a paged slot (4, 6 or 7). That access uses the page and then returns the unit to page 0 by itself. Accesses to the other slots leave a pending page alone.

Page 1 holds three registers:
- the live state field of the source handshake,
- a latched interface-clear event together with its interrupt mask,
- a bus-line status byte that reads low for each asserted line.

On page 0, the address status register in slot 6 has its otherwise unused top bit replaced by a flag that shows whether a received data byte is waiting.

Top module: `pgreg_access_unit`

## Requirements
- R1: The register slot is addr[4:2]. addr[1:0] is ignored. A page-0 access drives core_rd or core_wr in the same cycle, with core_slot equal to the slot and core_wdata equal to wdata. When wr_en and rd_en are both high, the access is treated as a write only.
- R2: A write to slot 5 whose data has upper nibble 0x5 sets the pending page to data[3:0] and is not forwarded. Any other slot-5 write is forwarded to the core.
- R3: An access to slot 4, 6 or 7 uses the pending page, and afterwards the pending page is 0.
- R4: An access to slot 0, 1, 2, 3 or 5, other than a page command, leaves the pending page unchanged and is forwarded to the core.
- R5: On page 1, a read of slot 4 returns {5'b0, hs_state}. Page-1 accesses are never forwarded, and writes to page-1 slots 4 and 7 change nothing.
- R6: On page 1, a read of slot 7 returns the bus status byte. Bit 0 is ATN, bit 1 is EOI, bit 2 is SRQ, bit 3 is IFC, bit 4 is REN, bit 5 is DAV, bit 6 is NRFD and bit 7 is NDAC. Each bit reads 0 while the matching line is asserted in bus_asserted.
- R7: Interrupt status bit 3 (page 1, slot 6, read) is set on a rising edge of bus_asserted[3]. A read of that register returns the value before clearing and clears the bit at the end of the cycle. A rising edge in the same cycle as the read leaves the bit set.
- R8: A write to page 1, slot 6 loads the interrupt mask byte. irq is high exactly when some status bit and its mask bit are both set, one cycle after the status or the mask changes.
- R9: A page-0 read of slot 6 returns core_rdata[6:0], with bit 7 replaced by data_in_ready.
- R10: After reset, the pending page, the interrupt status and the mask are all 0, so irq is low.
- R11: With a pending page other than 0 or 1, an access to a paged slot reads 0, is not forwarded, has no effect and clears the page.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 8 | CPU byte address |
| wr_en | input | 1 | CPU write strobe, one cycle per access |
| rd_en | input | 1 | CPU read strobe, one cycle per access |
| wdata | input | 8 | CPU write data |
| rdata | output | 8 | CPU read data, valid while rd_en is high |
| bus_asserted | input | 8 | Bus lines, 1 = asserted, in R6 bit order |
| hs_state | input | 3 | Source handshake state code |
| data_in_ready | input | 1 | Received byte waiting in the core |
| core_rdata | input | 8 | Core register read data for core_slot |
| core_rd | output | 1 | Forwarded read strobe |
| core_wr | output | 1 | Forwarded write strobe |
| core_slot | output | 3 | Forwarded register slot |
| core_wdata | output | 8 | Forwarded write data |
| irq | output | 1 | Interrupt request |

## Verification
The bench targets the one-shot page corner cases:
- A page pending across accesses to unpaged slots. A design that cleared the page on any access would then forward the later page-1 read to the core.
- A second access after a paged one. A design that kept the page would keep reading bus status instead of core data.
- Undefined pages 2 to 15. A design that treated them as page 0 would forward the access.

For the interface-clear latch, it checks:
- read-to-clear, where a wrong design would return 0 on the first read or keep the bit set;
- a rising edge that coincides with the clearing read, where clear priority would lose the event;
- masking, where irq must stay low until the mask bit is written.

// File: rtl/pgreg_pkg.sv
package pgreg_pkg;

    localparam int SLOT_W   = 3;
    localparam int DATA_W   = 8;
    localparam int PAGE_W   = 4;
    localparam int HS_W     = 3;
    localparam int IFC_BIT  = 3;

    typedef logic [SLOT_W-1:0] slot_t;
    typedef logic [PAGE_W-1:0] page_t;
    typedef logic [DATA_W-1:0] byte_t;

    // slot roles; paged slots are the ones with an alternate meaning on page 1
    localparam slot_t SLOT_HS   = 3'd4;
    localparam slot_t SLOT_AUX  = 3'd5;
    localparam slot_t SLOT_ADR0 = 3'd6;
    localparam slot_t SLOT_IRQ0 = 3'd6;
    localparam slot_t SLOT_BUS  = 3'd7;

    localparam logic [3:0] PAGE_CMD_CODE = 4'h5;
    localparam page_t      PAGE_ALT      = 4'd1;

    typedef struct packed {
        page_t page;
    } page_state_t;

    typedef struct packed {
        logic  ifc_prev;
        byte_t stat;
        byte_t mask;
    } irq_state_t;

    function automatic logic is_paged(input slot_t s);
        return (s == SLOT_HS) || (s == SLOT_IRQ0) || (s == SLOT_BUS);
    endfunction

endpackage

// File: rtl/pgreg_page_ctrl.sv
module pgreg_page_ctrl
    import pgreg_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  acc_rd,
    input  logic  acc_wr,
    input  slot_t slot,
    input  byte_t wdata,
    output page_t page_q,
    output page_t eff_page,
    output logic  page_cmd
);

    page_state_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        page_cmd = acc_wr && (slot == SLOT_AUX) && (wdata[7:4] == PAGE_CMD_CODE);
        if (page_cmd) begin
            st_d.page = wdata[PAGE_W-1:0];
        end else if ((acc_rd || acc_wr) && is_paged(slot)) begin
            st_d.page = '0;
        end
        eff_page = is_paged(slot) ? st_q.page : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign page_q = st_q.page;

endmodule

// File: rtl/pgreg_ifc_irq.sv
module pgreg_ifc_irq
    import pgreg_pkg::*;
#(
    parameter int EVENT_BIT = IFC_BIT
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  ifc_line,
    input  logic  stat_clr,
    input  logic  mask_we,
    input  byte_t mask_wdata,
    output byte_t stat_q,
    output byte_t mask_q,
    output logic  irq
);

    irq_state_t st_d, st_q;
    logic       ifc_rise;

    always_comb begin
        st_d          = st_q;
        ifc_rise      = ifc_line && !st_q.ifc_prev;
        st_d.ifc_prev = ifc_line;
        if (stat_clr) begin
            st_d.stat = '0;
        end
        if (ifc_rise) begin
            st_d.stat[EVENT_BIT] = 1'b1;
        end
        if (mask_we) begin
            st_d.mask = mask_wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign stat_q = st_q.stat;
    assign mask_q = st_q.mask;
    assign irq    = |(st_q.stat & st_q.mask);

endmodule

// File: rtl/pgreg_rd_mux.sv
module pgreg_rd_mux
    import pgreg_pkg::*;
(
    input  slot_t           slot,
    input  page_t           eff_page,
    input  logic [HS_W-1:0] hs_state,
    input  byte_t           bus_asserted,
    input  byte_t           stat,
    input  byte_t           core_rdata,
    input  logic            data_in_ready,
    output byte_t           rdata
);

    always_comb begin
        rdata = '0;
        if (eff_page == '0) begin
            rdata = core_rdata;
            if (slot == SLOT_ADR0) begin
                rdata[DATA_W-1] = data_in_ready;
            end
        end else if (eff_page == PAGE_ALT) begin
            case (slot)
                SLOT_HS:   rdata = {{(DATA_W-HS_W){1'b0}}, hs_state};
                SLOT_IRQ0: rdata = stat;
                SLOT_BUS:  rdata = ~bus_asserted;
                default:   rdata = '0;
            endcase
        end
    end

endmodule

// File: rtl/pgreg_access_unit.sv
module pgreg_access_unit
    import pgreg_pkg::*;
#(
    parameter int ADDR_W      = 8,
    parameter int STRIDE_LOG2 = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [7:0]        wdata,
    output logic [7:0]        rdata,
    input  logic [7:0]        bus_asserted,
    input  logic [2:0]        hs_state,
    input  logic              data_in_ready,
    input  logic [7:0]        core_rdata,
    output logic              core_rd,
    output logic              core_wr,
    output logic [2:0]        core_slot,
    output logic [7:0]        core_wdata,
    output logic              irq
);

    localparam int SLOT_LSB = STRIDE_LOG2;
    localparam int SLOT_MSB = STRIDE_LOG2 + SLOT_W - 1;

    slot_t acc_slot;
    logic  acc_rd, acc_wr;
    page_t page_q, eff_page;
    logic  page_cmd, local_hit, alt_irq0;
    byte_t stat_q, mask_q;
    logic  unused_addr_bits;

    assign acc_slot         = addr[SLOT_MSB:SLOT_LSB];
    assign unused_addr_bits = ^{addr[SLOT_LSB-1:0], addr[ADDR_W-1:SLOT_MSB+1]};
    assign acc_wr           = wr_en;
    assign acc_rd           = rd_en && !wr_en;

    pgreg_page_ctrl page_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .acc_rd   (acc_rd),
        .acc_wr   (acc_wr),
        .slot     (acc_slot),
        .wdata    (wdata),
        .page_q   (page_q),
        .eff_page (eff_page),
        .page_cmd (page_cmd)
    );

    assign local_hit = (eff_page != '0);
    assign alt_irq0  = (eff_page == PAGE_ALT) && (acc_slot == SLOT_IRQ0);

    pgreg_ifc_irq #(.EVENT_BIT(IFC_BIT)) irq_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .ifc_line   (bus_asserted[IFC_BIT]),
        .stat_clr   (acc_rd && alt_irq0),
        .mask_we    (acc_wr && alt_irq0),
        .mask_wdata (wdata),
        .stat_q     (stat_q),
        .mask_q     (mask_q),
        .irq        (irq)
    );

    pgreg_rd_mux mux_i (
        .slot          (acc_slot),
        .eff_page      (eff_page),
        .hs_state      (hs_state),
        .bus_asserted  (bus_asserted),
        .stat          (stat_q),
        .core_rdata    (core_rdata),
        .data_in_ready (data_in_ready),
        .rdata         (rdata)
    );

    assign core_rd    = acc_rd && !local_hit;
    assign core_wr    = acc_wr && !local_hit && !page_cmd;
    assign core_slot  = acc_slot;
    assign core_wdata = wdata;

endmodule

// File: rtl/pgreg_access_unit_chk.sv
module pgreg_access_unit_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       rd_en,
    input logic       wr_en,
    input logic [2:0] slot,
    input logic [7:0] wdata,
    input logic [3:0] page_q,
    input logic       core_rd,
    input logic       core_wr,
    input logic       irq,
    input logic [7:0] mask_q,
    input logic       ifc_stat,
    input logic       ifc_line
);

    logic paged_acc, pg_cmd;
    assign paged_acc = (rd_en || wr_en) && (slot == 3'd4 || slot == 3'd6 || slot == 3'd7);
    assign pg_cmd    = wr_en && (slot == 3'd5) && (wdata[7:4] == 4'h5);

    // R2
    a_r2_page_load: assert property (@(posedge clk) disable iff (!rst_n)
        pg_cmd |=> page_q == $past(wdata[3:0]));

    // R3
    a_r3_page_clears: assert property (@(posedge clk) disable iff (!rst_n)
        paged_acc |=> page_q == 4'd0);

    // R4
    a_r4_page_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!paged_acc && !pg_cmd) |=> $stable(page_q));

    // R5, R11
    a_r5_no_fwd_alt: assert property (@(posedge clk) disable iff (!rst_n)
        (paged_acc && page_q != 4'd0) |-> (!core_rd && !core_wr));

    // R7
    a_r7_ifc_latch: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ifc_line) |=> ifc_stat);

    // R8
    a_r8_irq_needs_mask: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> mask_q[3]);

endmodule

bind pgreg_access_unit pgreg_access_unit_chk chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_en    (rd_en),
    .wr_en    (wr_en),
    .slot     (acc_slot),
    .wdata    (wdata),
    .page_q   (page_q),
    .core_rd  (core_rd),
    .core_wr  (core_wr),
    .irq      (irq),
    .mask_q   (mask_q),
    .ifc_stat (stat_q[3]),
    .ifc_line (bus_asserted[3])
);

// File: tb/pgreg_access_unit_tb_top.sv
module pgreg_access_unit_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] addr = '0;
    logic       wr_en = 1'b0, rd_en = 1'b0;
    logic [7:0] wdata = '0, rdata;
    logic [7:0] bus_asserted = '0;
    logic [2:0] hs_state = '0;
    logic       data_in_ready = 1'b0;
    logic [7:0] core_rdata = '0;
    logic       core_rd, core_wr, irq;
    logic [2:0] core_slot;
    logic [7:0] core_wdata;

    int checks = 0, errors = 0;
    bit done = 1'b0;

    // model state
    logic [3:0] m_page = '0;
    logic [7:0] m_stat = '0, m_mask = '0;
    logic       m_prev = 1'b0;

    always #2 clk = ~clk;

    pgreg_access_unit dut_i (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
        .wdata(wdata), .rdata(rdata), .bus_asserted(bus_asserted),
        .hs_state(hs_state), .data_in_ready(data_in_ready),
        .core_rdata(core_rdata), .core_rd(core_rd), .core_wr(core_wr),
        .core_slot(core_slot), .core_wdata(core_wdata), .irq(irq)
    );

    function automatic bit paged(input logic [2:0] s);
        return s == 3'd4 || s == 3'd6 || s == 3'd7;
    endfunction

    function automatic logic [7:0] exp_read(input logic [2:0] s, input logic [3:0] pg,
                                            input logic [7:0] core, input logic dir,
                                            input logic [2:0] hs, input logic [7:0] bus,
                                            input logic [7:0] stat);
        if (pg == 4'd0) return (s == 3'd6) ? {dir, core[6:0]} : core;
        if (pg != 4'd1) return 8'h00;
        case (s)
            3'd4:    return {5'b0, hs};
            3'd6:    return stat;
            3'd7:    return ~bus;
            default: return 8'h00;
        endcase
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic op(input bit is_wr, input logic [2:0] s, input logic [7:0] d,
                      input logic [7:0] bus, input string req);
        logic [3:0] eff;
        bit         pcmd, fwd, rise;
        logic [7:0] e;
        @(negedge clk);
        bus_asserted  = bus;
        addr          = {3'($urandom), s, 2'($urandom)};
        wr_en         = is_wr;
        rd_en         = !is_wr;
        wdata         = d;
        core_rdata    = 8'($urandom);
        hs_state      = 3'($urandom);
        data_in_ready = 1'($urandom);
        #1;
        eff  = paged(s) ? m_page : 4'd0;
        pcmd = is_wr && s == 3'd5 && d[7:4] == 4'h5;
        fwd  = (eff == 4'd0) && !pcmd;
        chk(irq == |(m_stat & m_mask), {req, " R8 irq"}, irq, |(m_stat & m_mask));
        if (is_wr) begin
            chk(core_wr == fwd && !core_rd, {req, " fwd write"}, core_wr, fwd);
            if (fwd) chk(core_wdata == d && core_slot == s, {req, " R1 write fields"},
                         {core_slot, core_wdata}, {s, d});
        end else begin
            e = exp_read(s, eff, core_rdata, data_in_ready, hs_state, bus, m_stat);
            chk(rdata == e, {req, " read data"}, rdata, e);
            chk(core_rd == fwd && !core_wr, {req, " fwd read"}, core_rd, fwd);
            if (fwd) chk(core_slot == s, {req, " R1 slot"}, core_slot, s);
        end
        @(posedge clk);
        #1;
        wr_en = 1'b0;
        rd_en = 1'b0;
        rise   = bus[3] && !m_prev;
        m_prev = bus[3];
        if (!is_wr && eff == 4'd1 && s == 3'd6) m_stat = '0;
        if (rise) m_stat[3] = 1'b1;
        if (is_wr && eff == 4'd1 && s == 3'd6) m_mask = d;
        if (pcmd) m_page = d[3:0];
        else if (paged(s)) m_page = 4'd0;
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED));
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        // R10: reset state
        chk(irq == 1'b0, "R10 irq after reset", irq, 0);
        op(0, 3'd7, 8'h00, 8'h00, "R10 page0 after reset");
        // R2, R6, R3
        op(1, 3'd5, 8'h51, 8'h00, "R2 page cmd");
        op(0, 3'd7, 8'h00, 8'hA5, "R6 bus status");
        op(0, 3'd7, 8'h00, 8'hA5, "R3 page reverted");
        op(1, 3'd5, 8'h02, 8'h00, "R2 other aux fwd");
        // R4 hold then R5
        op(1, 3'd5, 8'h51, 8'h00, "R4 setup");
        op(0, 3'd2, 8'h00, 8'h00, "R4 unpaged read");
        op(1, 3'd0, 8'h3C, 8'h00, "R4 unpaged write");
        op(1, 3'd5, 8'h11, 8'h00, "R4 aux non-page");
        op(0, 3'd4, 8'h00, 8'h00, "R5 hs state");
        op(1, 3'd5, 8'h51, 8'h00, "R5 setup");
        op(1, 3'd7, 8'hFF, 8'h00, "R5 write ignored");
        op(0, 3'd7, 8'h00, 8'h00, "R5 after ignored write");
        // R7 latch and read-clear
        op(1, 3'd5, 8'h51, 8'h08, "R7 ifc rise");
        op(0, 3'd6, 8'h00, 8'h08, "R7 read status");
        op(1, 3'd5, 8'h51, 8'h00, "R7 setup");
        op(0, 3'd6, 8'h00, 8'h00, "R7 cleared");
        op(1, 3'd5, 8'h51, 8'h00, "R7 setup");
        op(0, 3'd6, 8'h00, 8'h08, "R7 rise with clear");
        // R8 mask
        op(1, 3'd5, 8'h51, 8'h08, "R8 setup");
        op(1, 3'd6, 8'h08, 8'h08, "R8 mask write");
        op(0, 3'd1, 8'h00, 8'h08, "R8 irq high");
        op(1, 3'd5, 8'h51, 8'h08, "R8 setup");
        op(0, 3'd6, 8'h00, 8'h08, "R8 clear");
        op(0, 3'd1, 8'h00, 8'h08, "R8 irq low");
        // R9
        op(0, 3'd6, 8'h00, 8'h00, "R9 data ready bit");
        // R11
        op(1, 3'd5, 8'h53, 8'h00, "R11 setup");
        op(0, 3'd7, 8'h00, 8'h00, "R11 undefined page");
        op(1, 3'd5, 8'h5F, 8'h00, "R11 setup");
        op(1, 3'd6, 8'h08, 8'h00, "R11 write dropped");
        op(0, 3'd7, 8'h00, 8'h00, "R11 page reverted");
        // random mix
        for (int i = 0; i < 600; i++) begin
            logic [7:0] bus;
            logic [2:0] s;
            bus = bus_asserted;
            if ($urandom_range(0, 3) == 0) bus = 8'($urandom);
            s = 3'($urandom);
            case ($urandom_range(0, 3))
                0:       op(1, 3'd5, {4'h5, 2'b0, 2'($urandom_range(0, 2))}, bus, "R3 rnd page cmd");
                1:       op(1, s, 8'($urandom), bus, "R4 rnd write");
                default: op(0, s, 8'h00, bus, "R1 rnd read");
            endcase
        end
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule